// File: doc/BRIEF.md
# Delta-Sigma ADC Frame Readout Controller

This block is the host side of a four-wire serial link to a multichannel delta-sigma converter. When a readout is requested it drives chip select low and polls the converter's serial output. The converter holds that line high while a conversion is still running. Once the line reads low, the block generates exactly 32 serial clock pulses. On each rising edge it captures one frame bit. At the same time it shifts a configuration word out on the serial data input, and that word selects the channel and speed of the following conversion.

The captured frame opens with three status bits: end of conversion, an always-low filler bit and a sign bit. Twenty-four result bits follow, most significant first, and then five sub-LSB bits. The block turns the frame into a 29-bit two's-complement result. An out-of-range frame saturates to the extreme code and raises a separate flag. Each result is tagged with the channel that produced it. In the double-speed mode the converter delivers a result one conversion late, so the tag then names the channel of the conversion before. A scan mode steps round-robin through a programmable list of channel codes.

Configuration word layout, CFG_W = 2 + SPD_W + CH_W bits, sent most significant bit first: bit CFG_W-1 is update-enable, bit CFG_W-2 selects double speed, the next SPD_W bits hold the oversampling code, and the low CH_W bits hold the channel code.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, cs_n_o is high, sck_o is low, busy_o is low and res_valid_o is low, and the tracked channel is 0 in single-speed mode. A start_i pulse while idle drives cs_n_o low and raises busy_o.
- R2: While cs_n_o is low and sdo_i reads high (conversion running), sck_o stays low. Clocking begins only after sdo_i is sampled low with cs_n_o low, and sck_o is never high while cs_n_o is high.
- R3: Each low phase and each high phase of sck_o lasts SCK_HALF system clocks, with SCK_HALF of at least 2. A readout has exactly 32 rising edges, and cs_n_o rises together with the 32nd falling edge.
- R4: sdi_o carries the selected configuration word, most significant bit first, on the first CFG_W rising edges and is 0 on the remaining edges. It changes only while sck_o is low.
- R5: With frame bits 29:28 equal to 10 or 01, res_data_o equals frame bits 28:0 read as a 29-bit two's-complement number, and both flags are low.
- R6: Frame bits 29:28 equal to 11 give res_data_o = 0x0FFFFFFF with res_ovr_o high. Bits 29:28 equal to 00 give res_data_o = 0x10000000 with res_unr_o high. The two flags are never high together.
- R7: In single-speed mode res_chan_o is the channel in effect for the conversion just read. A word sent with update-enable set makes its channel and speed current. A word sent with update-enable clear leaves both unchanged.
- R8: When the conversion just read ran in double-speed mode, res_chan_o names the channel of the conversion before it.
- R9: With scan_en_i high, each readout sends entry k of scan_list_i (bits k*CH_W upward), with update-enable set and the speed fields taken from cfg_i. The index starts at 0 and wraps to 0 after entry scan_len_i-1.
- R10: res_valid_o is a single-cycle pulse, one per readout, issued after cs_n_o has risen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one frame readout (taken while idle) |
| scan_en_i | input | 1 | Take the channel from the scan list instead of cfg_i |
| cfg_i | input | CFG_W | Configuration word for the next conversion |
| scan_list_i | input | SCAN_DEPTH*CH_W | Packed list of channel codes, entry 0 in the low bits |
| scan_len_i | input | IDX_W | Number of scan list entries in use |
| busy_o | output | 1 | Readout in progress |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sck_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Serial configuration data to the converter |
| sdo_i | input | 1 | Serial frame data and conversion status from the converter |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | 29 | Signed result |
| res_ovr_o | output | 1 | Input was above positive full scale |
| res_unr_o | output | 1 | Input was below negative full scale |
| res_chan_o | output | CH_W | Channel that produced this result |

## Verification
The bench aims at the range boundaries of the decode: the largest in-range positive code, minus one LSB, zero, and both saturating status codes. A decoder that read the frame one bit off, or treated the top result bit as a magnitude bit, would return a wrong value or a wrong sign at exactly these codes. It walks a channel history that mixes enable-clear words with a double-speed conversion. Tag logic that updated on every word, or ignored the lag, would name the wrong channel right after those transitions. A held-off conversion and a wrapping scan list check that no clock runs before the status bit drops, and that a scan pointer stepping one entry too far sends the wrong channel code.

// File: rtl/afr_pkg.sv
package afr_pkg;

   // Frame format of the converter
   localparam int FRAME_W = 32;
   localparam int DATA_W  = 24;
   localparam int SUB_W   = 5;
   localparam int RES_W   = DATA_W + SUB_W;
   localparam int CAP_W   = RES_W + 1;   // sign bit plus result and sub-LSBs

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_POLL,
      ST_SHIFT,
      ST_DONE
   } afr_state_e;

endpackage

// File: rtl/afr_sck_gen.sv
module afr_sck_gen #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sck_o,
   output logic rise_o,
   output logic fall_o
);

   localparam int CW = $clog2(HALF + 1);

   logic [CW-1:0] ph_cnt;
   logic          ph_end;

   assign ph_end = run_i && (ph_cnt == CW'(HALF - 1));
   assign rise_o = ph_end && !sck_o;
   assign fall_o = ph_end && sck_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_cnt <= '0;
         sck_o  <= 1'b0;
      end else if (!run_i) begin
         ph_cnt <= '0;
         sck_o  <= 1'b0;
      end else if (ph_end) begin
         ph_cnt <= '0;
         sck_o  <= ~sck_o;
      end else begin
         ph_cnt <= ph_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/afr_frame_decode.sv
module afr_frame_decode
   import afr_pkg::*;
#(
   parameter bit SATURATE = 1'b1
) (
   input  logic [CAP_W-1:0] cap_i,
   output logic [RES_W-1:0] data_o,
   output logic             ovr_o,
   output logic             unr_o
);

   localparam logic [RES_W-1:0] MAX_CODE = {1'b0, {(RES_W-1){1'b1}}};
   localparam logic [RES_W-1:0] MIN_CODE = {1'b1, {(RES_W-1){1'b0}}};

   logic             sgn;
   logic             top;
   logic [RES_W-1:0] raw;

   assign sgn = cap_i[CAP_W-1];
   assign top = cap_i[CAP_W-2];
   assign raw = {~sgn, cap_i[RES_W-2:0]};

   assign ovr_o = sgn & top;
   assign unr_o = ~sgn & ~top;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (ovr_o)      data_o = MAX_CODE;
            else if (unr_o) data_o = MIN_CODE;
            else            data_o = raw;
         end
      end else begin : g_raw
         assign data_o = {top, cap_i[RES_W-2:0]};
      end
   endgenerate

endmodule

// File: rtl/afr_cfg_select.sv
module afr_cfg_select #(
   parameter int CH_W  = 4,
   parameter int SPD_W = 4,
   parameter int DEPTH = 4,
   localparam int CFG_W = 2 + SPD_W + CH_W,
   localparam int IDX_W = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scan_en_i,
   input  logic [CFG_W-1:0]      cfg_i,
   input  logic [DEPTH*CH_W-1:0] list_i,
   input  logic [IDX_W-1:0]      len_i,
   input  logic                  advance_i,
   output logic [CFG_W-1:0]      word_o
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [CH_W-1:0]  entry [DEPTH];
   logic [PTR_W-1:0] ptr;
   logic [IDX_W-1:0] nxt;
   logic             last;

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_entry
         assign entry[gi] = list_i[gi*CH_W +: CH_W];
      end
   endgenerate

   assign nxt  = IDX_W'(ptr) + 1'b1;
   assign last = (nxt >= len_i) || (ptr == PTR_W'(DEPTH - 1));

   always_comb begin
      if (scan_en_i) word_o = {1'b1, cfg_i[CFG_W-2:CH_W], entry[ptr]};
      else           word_o = cfg_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr <= '0;
      else if (!scan_en_i) ptr <= '0;
      else if (advance_i)  ptr <= last ? '0 : ptr + 1'b1;
   end

endmodule

// File: rtl/afr_chan_track.sv
module afr_chan_track #(
   parameter int CH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            update_i,
   input  logic            en_i,
   input  logic            dbl_i,
   input  logic [CH_W-1:0] ch_i,
   output logic [CH_W-1:0] tag_o
);

   logic [CH_W-1:0] cur_ch;
   logic [CH_W-1:0] prev_ch;
   logic            cur_dbl;

   // double-speed results lag by one conversion
   assign tag_o = cur_dbl ? prev_ch : cur_ch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_ch  <= '0;
         prev_ch <= '0;
         cur_dbl <= 1'b0;
      end else if (update_i) begin
         prev_ch <= cur_ch;
         if (en_i) begin
            cur_ch  <= ch_i;
            cur_dbl <= dbl_i;
         end
      end
   end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
   import afr_pkg::*;
#(
   parameter int CH_W       = 4,
   parameter int SPD_W      = 4,
   parameter int SCAN_DEPTH = 4,
   parameter int SCK_HALF   = 2,
   parameter bit SATURATE   = 1'b1,
   localparam int CFG_W     = 2 + SPD_W + CH_W,
   localparam int IDX_W     = $clog2(SCAN_DEPTH + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic                       scan_en_i,
   input  logic [CFG_W-1:0]           cfg_i,
   input  logic [SCAN_DEPTH*CH_W-1:0] scan_list_i,
   input  logic [IDX_W-1:0]           scan_len_i,
   output logic                       busy_o,
   output logic                       cs_n_o,
   output logic                       sck_o,
   output logic                       sdi_o,
   input  logic                       sdo_i,
   output logic                       res_valid_o,
   output logic [RES_W-1:0]           res_data_o,
   output logic                       res_ovr_o,
   output logic                       res_unr_o,
   output logic [CH_W-1:0]            res_chan_o
);

   localparam int BIT_W = $clog2(FRAME_W);

   generate
      if (SCK_HALF < 2) begin : g_bad_half
         $error("SCK_HALF must be at least 2");
      end
      if (CFG_W > FRAME_W) begin : g_bad_cfg
         $error("configuration word longer than the frame");
      end
      if (SCAN_DEPTH < 1) begin : g_bad_depth
         $error("SCAN_DEPTH must be at least 1");
      end
   endgenerate

   afr_state_e       state;
   logic [FRAME_W-1:0] tx_sr;
   logic [CAP_W-1:0] rx_sr;
   logic [BIT_W-1:0] bit_cnt;
   logic [CFG_W-1:0] word_sel;
   logic [CFG_W-1:0] word_q;
   logic             cs_n_q;
   logic             sck_rise;
   logic             sck_fall;
   logic             take;
   logic [RES_W-1:0] dec_data;
   logic             dec_ovr;
   logic             dec_unr;
   logic [CH_W-1:0]  tag;

   assign take   = (state == ST_IDLE) && start_i;
   assign busy_o = (state != ST_IDLE);
   assign cs_n_o = cs_n_q;
   assign sdi_o  = !cs_n_q && tx_sr[FRAME_W-1];

   afr_sck_gen #(.HALF(SCK_HALF)) u_sck (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state == ST_SHIFT),
      .sck_o  (sck_o),
      .rise_o (sck_rise),
      .fall_o (sck_fall)
   );

   afr_cfg_select #(.CH_W(CH_W), .SPD_W(SPD_W), .DEPTH(SCAN_DEPTH)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .scan_en_i (scan_en_i),
      .cfg_i     (cfg_i),
      .list_i    (scan_list_i),
      .len_i     (scan_len_i),
      .advance_i (take && scan_en_i),
      .word_o    (word_sel)
   );

   afr_frame_decode #(.SATURATE(SATURATE)) u_dec (
      .cap_i  (rx_sr),
      .data_o (dec_data),
      .ovr_o  (dec_ovr),
      .unr_o  (dec_unr)
   );

   afr_chan_track #(.CH_W(CH_W)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .update_i (state == ST_DONE),
      .en_i     (word_q[CFG_W-1]),
      .dbl_i    (word_q[CFG_W-2]),
      .ch_i     (word_q[CH_W-1:0]),
      .tag_o    (tag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cs_n_q      <= 1'b1;
         tx_sr       <= '0;
         rx_sr       <= '0;
         bit_cnt     <= '0;
         word_q      <= '0;
         res_valid_o <= 1'b0;
         res_data_o  <= '0;
         res_ovr_o   <= 1'b0;
         res_unr_o   <= 1'b0;
         res_chan_o  <= '0;
      end else begin
         res_valid_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_i) begin
                  state   <= ST_POLL;
                  cs_n_q  <= 1'b0;
                  tx_sr   <= {word_sel, {(FRAME_W-CFG_W){1'b0}}};
                  word_q  <= word_sel;
                  bit_cnt <= '0;
               end
            end
            ST_POLL: begin
               if (!sdo_i) state <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (sck_rise) rx_sr <= {rx_sr[CAP_W-2:0], sdo_i};
               if (sck_fall) begin
                  tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
                  if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
                     state  <= ST_DONE;
                     cs_n_q <= 1'b1;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            ST_DONE: begin
               res_valid_o <= 1'b1;
               res_data_o  <= dec_data;
               res_ovr_o   <= dec_ovr;
               res_unr_o   <= dec_unr;
               res_chan_o  <= tag;
               state       <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/afr_checker.sv
module afr_checker
   import afr_pkg::*;
#(
   parameter int CH_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy_o,
   input logic             cs_n_o,
   input logic             sck_o,
   input logic             sdi_o,
   input logic             res_valid_o,
   input logic [RES_W-1:0] res_data_o,
   input logic             res_ovr_o,
   input logic             res_unr_o,
   input logic [CH_W-1:0]  res_chan_o
);

   localparam logic [RES_W-1:0] MAXC = {1'b0, {(RES_W-1){1'b1}}};
   localparam logic [RES_W-1:0] MINC = {1'b1, {(RES_W-1){1'b0}}};

   a_r1_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> cs_n_o);

   a_r2_no_sck_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      sck_o |-> !cs_n_o);

   a_r3_high_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_o) |=> sck_o);

   a_r3_low_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sck_o) && !cs_n_o) |=> !sck_o);

   a_r4_sdi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_o && $past(sck_o)) |-> $stable(sdi_o));

   a_r6_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> !(res_ovr_o && res_unr_o));

   a_r6_ovr_max: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_ovr_o) |-> (res_data_o == MAXC));

   a_r6_unr_min: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_unr_o) |-> (res_data_o == MINC));

   a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |=> !res_valid_o);

   a_r10_valid_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> (cs_n_o && !busy_o));

endmodule

bind adc_frame_reader afr_checker #(.CH_W(CH_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_o      (busy_o),
   .cs_n_o      (cs_n_o),
   .sck_o       (sck_o),
   .sdi_o       (sdi_o),
   .res_valid_o (res_valid_o),
   .res_data_o  (res_data_o),
   .res_ovr_o   (res_ovr_o),
   .res_unr_o   (res_unr_o),
   .res_chan_o  (res_chan_o)
);

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;

   localparam int CH_W  = 4;
   localparam int SPD_W = 4;
   localparam int DEPTH = 4;
   localparam int CFG_W = 2 + SPD_W + CH_W;
   localparam int IDX_W = $clog2(DEPTH + 1);
   localparam int NV    = 7;

   // frame, word sent, expected result, ovr, unr, tag
   localparam logic [31:0]      V_FRM [NV] = '{32'h2123_4567, 32'h1FFF_FFF0, 32'h3000_0AAA,
                                              32'h0000_0055, 32'h2000_0000, 32'h1FFF_FFFF,
                                              32'h2FFF_FFFF};
   localparam logic [CFG_W-1:0] V_CFG [NV] = '{10'h225, 10'h009, 10'h313, 10'h207,
                                              10'h202, 10'h000, 10'h00F};
   localparam logic [28:0]      V_RES [NV] = '{29'h0123_4567, 29'h1FFF_FFF0, 29'h0FFF_FFFF,
                                              29'h1000_0000, 29'h0000_0000, 29'h1FFF_FFFF,
                                              29'h0FFF_FFFF};
   localparam logic             V_OVR [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
   localparam logic             V_UNR [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
   localparam logic [CH_W-1:0]  V_TAG [NV] = '{4'd0, 4'd5, 4'd5, 4'd5, 4'd7, 4'd2, 4'd2};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic scan_en_i = 1'b0;
   logic [CFG_W-1:0] cfg_i = '0;
   logic [DEPTH*CH_W-1:0] scan_list_i = '0;
   logic [IDX_W-1:0] scan_len_i = '0;
   logic busy_o, cs_n_o, sck_o, sdi_o, sdo_i;
   logic res_valid_o, res_ovr_o, res_unr_o;
   logic [28:0] res_data_o;
   logic [CH_W-1:0] res_chan_o;

   int checks = 0;
   int fails = 0;

   // converter model
   logic [31:0] dev_frame = 32'h0;
   int conv_len = 6;
   int conv_cnt = 40;
   int bidx = 31;
   int rises = 0;
   logic [31:0] rx_bits = '0;
   logic sck_prev = 1'b0;
   logic cs_prev = 1'b1;

   always #4 clk = ~clk;

   adc_frame_reader #(.CH_W(CH_W), .SPD_W(SPD_W), .SCAN_DEPTH(DEPTH), .SCK_HALF(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .scan_en_i(scan_en_i), .cfg_i(cfg_i),
      .scan_list_i(scan_list_i), .scan_len_i(scan_len_i), .busy_o(busy_o), .cs_n_o(cs_n_o),
      .sck_o(sck_o), .sdi_o(sdi_o), .sdo_i(sdo_i), .res_valid_o(res_valid_o),
      .res_data_o(res_data_o), .res_ovr_o(res_ovr_o), .res_unr_o(res_unr_o),
      .res_chan_o(res_chan_o)
   );

   assign sdo_i = (conv_cnt != 0) ? 1'b1 : dev_frame[bidx];

   always @(negedge clk) begin
      if (cs_prev && !cs_n_o) begin
         bidx = 31; rises = 0; rx_bits = '0;
      end else if (!cs_prev && cs_n_o) begin
         conv_cnt = conv_len;
      end else if (conv_cnt != 0) begin
         conv_cnt = conv_cnt - 1;
      end
      if (!sck_prev && sck_o) begin
         rx_bits = {rx_bits[30:0], sdi_o};
         rises = rises + 1;
      end
      if (sck_prev && !sck_o && bidx > 0) bidx = bidx - 1;
      sck_prev = sck_o;
      cs_prev = cs_n_o;
   end

   task automatic chk(input logic ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic readout(input logic [31:0] frm);
      dev_frame = frm;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      while (!res_valid_o) @(negedge clk);
   endtask

   task automatic post_checks(input logic [CFG_W-1:0] exp_word, input logic [CH_W-1:0] exp_tag,
                              input string tagreq);
      chk(res_chan_o == exp_tag, tagreq, 64'(res_chan_o), 64'(exp_tag));
      chk(rx_bits[31:32-CFG_W] == exp_word, "R4 word on sdi", 64'(rx_bits[31:32-CFG_W]),
          64'(exp_word));
      chk(rx_bits[31-CFG_W:0] == '0, "R4 trailing zeros", 64'(rx_bits[31-CFG_W:0]), 64'h0);
      chk(rises == 32, "R3 rising edge count", 64'(rises), 64'd32);
      @(negedge clk);
      chk(res_valid_o == 1'b0, "R10 single pulse", 64'(res_valid_o), 64'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(cs_n_o && !sck_o && !busy_o && !res_valid_o, "R1 reset outputs",
          64'({cs_n_o, sck_o, busy_o, res_valid_o}), 64'h8);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cs_n_o && !busy_o, "R1 idle after reset", 64'({cs_n_o, busy_o}), 64'h2);

      // table walk: decode (R5, R6) and tagging (R7, R8)
      for (int i = 0; i < NV; i++) begin
         cfg_i = V_CFG[i];
         readout(V_FRM[i]);
         chk(res_data_o == V_RES[i], (V_OVR[i] || V_UNR[i]) ? "R6 saturated data" : "R5 data",
             64'(res_data_o), 64'(V_RES[i]));
         chk(res_ovr_o == V_OVR[i], "R6 ovr flag", 64'(res_ovr_o), 64'(V_OVR[i]));
         chk(res_unr_o == V_UNR[i], "R6 unr flag", 64'(res_unr_o), 64'(V_UNR[i]));
         post_checks(V_CFG[i], V_TAG[i], (i == 3) ? "R8 lagged tag" : "R7 tag");
      end

      // R9 scan: list {1,4,6,8}, length 3, speed 3
      scan_list_i = 16'h8641;
      scan_len_i  = 3'd3;
      cfg_i       = 10'h030;
      scan_en_i   = 1'b1;
      begin
         logic [CFG_W-1:0] sw [4] = '{10'h231, 10'h234, 10'h236, 10'h231};
         logic [CH_W-1:0]  st [4] = '{4'd2, 4'd1, 4'd4, 4'd6};
         for (int k = 0; k < 4; k++) begin
            readout(32'h2123_4567);
            chk(rx_bits[31:32-CFG_W] == sw[k], "R9 scan entry", 64'(rx_bits[31:32-CFG_W]),
                64'(sw[k]));
            post_checks(sw[k], st[k], "R9 scan tag");
         end
      end
      scan_en_i = 1'b0;

      // R2 long conversion: no clock while status is high
      cfg_i = 10'h000;
      conv_len = 300;
      readout(32'h2000_0000);
      @(negedge clk);
      conv_len = 6;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      begin
         int rise_seen = 0;
         for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (sck_o) rise_seen++;
         end
         chk(rise_seen == 0, "R2 sck held during conversion", 64'(rise_seen), 64'h0);
         chk(!cs_n_o && busy_o, "R1 cs low while polling", 64'({cs_n_o, busy_o}), 64'h1);
      end
      while (!res_valid_o) @(negedge clk);
      chk(res_data_o == 29'h0 && rises == 32, "R2 readout after conversion",
          64'(res_data_o), 64'h0);

      // R3 phase width: sck high lasts exactly two clocks
      dev_frame = 32'h2000_0001;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      while (!sck_o) @(negedge clk);
      @(negedge clk);
      chk(sck_o == 1'b1, "R3 high phase second clock", 64'(sck_o), 64'h1);
      @(negedge clk);
      chk(sck_o == 1'b0, "R3 high phase ends", 64'(sck_o), 64'h0);
      @(negedge clk);
      chk(sck_o == 1'b0, "R3 low phase second clock", 64'(sck_o), 64'h0);
      while (!res_valid_o) @(negedge clk);
      chk(res_data_o == 29'h1, "R5 one LSB", 64'(res_data_o), 64'h1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule